// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block sits beside a small 8-bit processor core and performs the memory traffic for entering and leaving an interrupt handler. When the core raises a software interrupt, or when a hardware interrupt is pending at an instruction boundary, the sequencer captures the live register set and writes it to a stack that grows toward lower addresses. It then sets the interrupt mask bit and fetches a new program counter from a two-byte vector. On a return request it reads the same frame back and rebuilds every register from it.

The memory side is a single byte-wide port. Each cycle carries at most one access, and read data is expected in the same cycle as the address. The core drives its current registers on the `*_in` ports and, once `done` pulses, takes the updated set from the `*_out` ports. `busy` stays high for the whole sequence. Requests that arrive while `busy` is high are not accepted.

Top module: `irq_ctx_seq`

## Requirements
- R1: An interrupt entry writes seven bytes to addresses SP, SP-1, ..., SP-6 in this order: PC[7:0], PC[15:8], IX[7:0], IX[15:8], A, B, then the condition byte.
- R2: The condition byte written to the stack is {2'b11, ccr_in[5:0]}, where ccr_in bit 5 is H, bit 4 is I, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R3: After an entry, sp_out equals sp_in minus 7, and ccr_out equals ccr_in with bit 4 (I) set. ix_out, a_out and b_out equal their inputs.
- R4: The new PC is read big-endian, with the high byte at the lower address. The vector pairs are 0xFFFA/0xFFFB for software, 0xFFFC/0xFFFD for NMI and 0xFFF8/0xFFF9 for IRQ.
- R5: A falling edge on nmi_n is held pending until it is taken at an instruction boundary (insn_end high). Holding nmi_n low does not start a second entry.
- R6: An IRQ entry starts only when irq_n is low, ccr_in bit 4 is 0 and insn_end is high.
- R7: When several requests are presented together, the one taken is chosen in the order NMI, IRQ, software interrupt, return.
- R8: A return reads addresses SP+1 through SP+7 and restores, in that order, CCR, B, A, IX[15:8], IX[7:0], PC[15:8] and PC[7:0]. Bits 7 and 6 of the stacked condition byte are ignored, and sp_out equals sp_in plus 7.
- R9: done rises 10 clock edges after the edge that accepts an entry and 8 edges after the edge that accepts a return. A return performs no writes.
- R10: busy is high from acceptance until done. Software, return and IRQ requests presented while busy is high are dropped. An NMI edge that falls while busy is high stays pending.
- R11: done is high for exactly one cycle, and busy is low in the following cycle.
- R12: While reset is asserted, and in the first cycle after it, busy, done and mem_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_end | input | 1 | Instruction boundary; hardware interrupts may be taken |
| swi_req | input | 1 | Software interrupt request |
| rti_req | input | 1 | Return-from-interrupt request |
| nmi_n | input | 1 | Non-maskable interrupt, active low, edge detected |
| irq_n | input | 1 | Maskable interrupt, active low, level |
| pc_in | input | 16 | Live program counter (address of next instruction) |
| ix_in | input | 16 | Live index register |
| a_in | input | 8 | Live accumulator A |
| b_in | input | 8 | Live accumulator B |
| ccr_in | input | 6 | Live condition bits {H,I,N,Z,V,C} |
| sp_in | input | 16 | Live stack pointer |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_addr |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| pc_out | output | 16 | Resulting program counter |
| ix_out | output | 16 | Resulting index register |
| a_out | output | 8 | Resulting accumulator A |
| b_out | output | 8 | Resulting accumulator B |
| ccr_out | output | 6 | Resulting condition bits |
| sp_out | output | 16 | Resulting stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench checks each stacked byte at its exact address. A design that swapped the high and low halves of PC or IX, or that stored the condition byte without its two forced ones, would show the wrong byte at a known stack slot. Return frames are seeded with random values in bits 7 and 6, so a design that did not mask those bits would corrupt ccr_out. The bench presents simultaneous requests, a held-low NMI, an IRQ that is masked and an IRQ raised off the instruction boundary. These expose a wrong priority, level-triggered NMI handling, or an IRQ taken with I set. An NMI edge that falls while the block is busy must still be taken afterwards, and a software request made in mid-sequence must vanish. The bench also counts cycles to done, which catches a missing or extra stack access.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int CCR_W     = 6;
    localparam int FRAME_LEN = 7;
    localparam int IDX_W     = $clog2(FRAME_LEN + 1);
    localparam int CCR_I_BIT = 4;
    localparam int PAD_W     = BYTE_W - CCR_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_POP,
        ST_FIN
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_IRQ,
        SRC_SWI,
        SRC_RTI
    } src_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ix;
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [CCR_W-1:0]  ccr;
        logic [ADDR_W-1:0] sp;
    } ctx_t;

    // Byte stored in slot k of the frame; slot 0 lands at the highest address.
    function automatic logic [BYTE_W-1:0] frame_byte(input logic [IDX_W-1:0] k, input ctx_t c);
        logic [BYTE_W-1:0] v;
        case (k)
            IDX_W'(0): v = c.pc[7:0];
            IDX_W'(1): v = c.pc[15:8];
            IDX_W'(2): v = c.ix[7:0];
            IDX_W'(3): v = c.ix[15:8];
            IDX_W'(4): v = c.a;
            IDX_W'(5): v = c.b;
            default:   v = {{PAD_W{1'b1}}, c.ccr};
        endcase
        return v;
    endfunction

    // Applies pop step k: stack pointer pre-increments, one register byte restored.
    function automatic ctx_t pop_step(input logic [IDX_W-1:0] k, input ctx_t c,
                                      input logic [BYTE_W-1:0] d);
        ctx_t r;
        r    = c;
        r.sp = c.sp + 1'b1;
        case (k)
            IDX_W'(0): r.ccr      = d[CCR_W-1:0];
            IDX_W'(1): r.b        = d;
            IDX_W'(2): r.a        = d;
            IDX_W'(3): r.ix[15:8] = d;
            IDX_W'(4): r.ix[7:0]  = d;
            IDX_W'(5): r.pc[15:8] = d;
            default:   r.pc[7:0]  = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqseq_nmi_latch.sv
module irqseq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic take,
    output logic pend
);
    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b1;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            pend  <= (pend & ~take) | (nmi_q & ~nmi_n);
        end
    end
endmodule

// File: rtl/irqseq_arbiter.sv
module irqseq_arbiter
    import irqseq_pkg::*;
(
    input  logic idle,
    input  logic insn_end,
    input  logic nmi_pend,
    input  logic irq_n,
    input  logic i_mask,
    input  logic swi_req,
    input  logic rti_req,
    output src_e src
);
    always_comb begin
        src = SRC_NONE;
        if (idle) begin
            if (insn_end && nmi_pend)                 src = SRC_NMI;
            else if (insn_end && !irq_n && !i_mask)   src = SRC_IRQ;
            else if (swi_req)                         src = SRC_SWI;
            else if (rti_req)                         src = SRC_RTI;
        end
    end
endmodule

// File: rtl/irqseq_engine.sv
module irqseq_engine
    import irqseq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_SWI = 16'hFFFA,
    parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFF8
) (
    input  logic              clk,
    input  logic              rst,
    input  src_e              src,
    input  ctx_t              ctx_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output ctx_t              ctx_out,
    output logic              busy,
    output logic              done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    seq_state_e        st;
    logic [IDX_W-1:0]  idx;
    ctx_t              ctx;
    logic [ADDR_W-1:0] vec;

    function automatic logic [ADDR_W-1:0] vec_of(input src_e s);
        case (s)
            SRC_NMI: return VEC_NMI;
            SRC_IRQ: return VEC_IRQ;
            default: return VEC_SWI;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            idx <= '0;
            ctx <= '0;
            vec <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (src != SRC_NONE) begin
                        ctx <= ctx_in;
                        idx <= '0;
                        vec <= vec_of(src);
                        st  <= (src == SRC_RTI) ? ST_POP : ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    ctx.sp <= ctx.sp - 1'b1;
                    idx    <= idx + 1'b1;
                    if (idx == LAST) begin
                        ctx.ccr[CCR_I_BIT] <= 1'b1;
                        st                 <= ST_VEC_HI;
                    end
                end
                ST_VEC_HI: begin
                    ctx.pc[15:8] <= mem_rdata;
                    st           <= ST_VEC_LO;
                end
                ST_VEC_LO: begin
                    ctx.pc[7:0] <= mem_rdata;
                    st          <= ST_FIN;
                end
                ST_POP: begin
                    ctx <= pop_step(idx, ctx, mem_rdata);
                    idx <= idx + 1'b1;
                    if (idx == LAST) st <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (st)
            ST_PUSH: begin
                mem_addr  = ctx.sp;
                mem_we    = 1'b1;
                mem_wdata = frame_byte(idx, ctx);
            end
            ST_POP:    mem_addr = ctx.sp + 1'b1;
            ST_VEC_HI: mem_addr = vec;
            ST_VEC_LO: mem_addr = vec + 1'b1;
            default:   mem_addr = '0;
        endcase
    end

    assign ctx_out = ctx;
    assign busy    = (st != ST_IDLE);
    assign done    = (st == ST_FIN);
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irqseq_pkg::*;
#(
    parameter logic [15:0] VEC_SWI = 16'hFFFA,
    parameter logic [15:0] VEC_NMI = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ = 16'hFFF8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_end,
    input  logic        swi_req,
    input  logic        rti_req,
    input  logic        nmi_n,
    input  logic        irq_n,
    input  logic [15:0] pc_in,
    input  logic [15:0] ix_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  b_in,
    input  logic [5:0]  ccr_in,
    input  logic [15:0] sp_in,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic [15:0] pc_out,
    output logic [15:0] ix_out,
    output logic [7:0]  a_out,
    output logic [7:0]  b_out,
    output logic [5:0]  ccr_out,
    output logic [15:0] sp_out,
    output logic        busy,
    output logic        done
);
    src_e src;
    logic nmi_pend;
    ctx_t ctx_in, ctx_res;

    assign ctx_in = '{pc: pc_in, ix: ix_in, a: a_in, b: b_in, ccr: ccr_in, sp: sp_in};

    irqseq_nmi_latch u_nmi (
        .clk  (clk),
        .rst  (rst),
        .nmi_n(nmi_n),
        .take (src == SRC_NMI),
        .pend (nmi_pend)
    );

    irqseq_arbiter u_arb (
        .idle    (!busy),
        .insn_end(insn_end),
        .nmi_pend(nmi_pend),
        .irq_n   (irq_n),
        .i_mask  (ccr_in[CCR_I_BIT]),
        .swi_req (swi_req),
        .rti_req (rti_req),
        .src     (src)
    );

    irqseq_engine #(
        .VEC_SWI(VEC_SWI),
        .VEC_NMI(VEC_NMI),
        .VEC_IRQ(VEC_IRQ)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .ctx_in   (ctx_in),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .ctx_out  (ctx_res),
        .busy     (busy),
        .done     (done)
    );

    assign pc_out  = ctx_res.pc;
    assign ix_out  = ctx_res.ix;
    assign a_out   = ctx_res.a;
    assign b_out   = ctx_res.b;
    assign ccr_out = ctx_res.ccr;
    assign sp_out  = ctx_res.sp;
endmodule

// File: rtl/irqseq_checker.sv
module irqseq_checker #(
    parameter logic [15:0] VEC_SWI = 16'hFFFA,
    parameter logic [15:0] VEC_NMI = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ = 16'hFFF8
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mem_we,
    input logic [15:0] mem_addr
);
    a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    a_r10_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    a_r1_push_descends: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    a_r4_vector_after_push: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_we) && !mem_we) |->
            (busy && (mem_addr == VEC_SWI || mem_addr == VEC_NMI || mem_addr == VEC_IRQ)));

    a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !mem_we));
endmodule

bind irq_ctx_seq irqseq_checker #(
    .VEC_SWI(VEC_SWI),
    .VEC_NMI(VEC_NMI),
    .VEC_IRQ(VEC_IRQ)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .mem_we  (mem_we),
    .mem_addr(mem_addr)
);

// File: tb/irq_ctx_seq_test.sv
module irq_ctx_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_end = 1'b0, swi_req = 1'b0, rti_req = 1'b0;
    logic        nmi_n = 1'b1, irq_n = 1'b1;
    logic [15:0] pc_in = '0, ix_in = '0, sp_in = '0;
    logic [7:0]  a_in = '0, b_in = '0;
    logic [5:0]  ccr_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [15:0] pc_out, ix_out, sp_out;
    logic [7:0]  a_out, b_out;
    logic [5:0]  ccr_out;
    logic        busy, done;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] mem [0:1023];

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

    irq_ctx_seq uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem[a[9:0]];
    endfunction

    // Waits for done; returns edges counted from the accepting edge.
    task automatic wait_done(output int edges);
        edges = 0;
        @(posedge clk); edges++;
        @(negedge clk);
        swi_req = 0; rti_req = 0; insn_end = 0;
        while (!done && edges < 60) begin
            @(posedge clk); edges++;
            @(negedge clk);
        end
        @(negedge clk);
        chk("R11 done width", {31'd0, done}, 0);
        chk("R11 busy after done", {31'd0, busy}, 0);
    endtask

    task automatic set_ctx(input logic [15:0] pc, input logic [15:0] ix, input logic [7:0] a,
                           input logic [7:0] b, input logic [5:0] ccr, input logic [15:0] sp);
        pc_in = pc; ix_in = ix; a_in = a; b_in = b; ccr_in = ccr; sp_in = sp;
    endtask

    // Checks a pushed frame and the post-entry register set.
    task automatic chk_entry(input logic [15:0] pc, input logic [15:0] ix, input logic [7:0] a,
                             input logic [7:0] b, input logic [5:0] ccr, input logic [15:0] sp,
                             input logic [15:0] vec);
        chk("R1 pcl", rd(sp),       pc[7:0]);
        chk("R1 pch", rd(sp - 1),   pc[15:8]);
        chk("R1 ixl", rd(sp - 2),   ix[7:0]);
        chk("R1 ixh", rd(sp - 3),   ix[15:8]);
        chk("R1 a",   rd(sp - 4),   a);
        chk("R1 b",   rd(sp - 5),   b);
        chk("R2 ccr byte", rd(sp - 6), {2'b11, ccr});
        chk("R3 sp",  sp_out, sp - 16'd7);
        chk("R3 ccr", ccr_out, ccr | 6'h10);
        chk("R3 ix",  ix_out, ix);
        chk("R3 a",   a_out, a);
        chk("R3 b",   b_out, b);
        chk("R4 pc",  pc_out, {rd(vec), rd(vec + 1)});
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e;
        logic [15:0] pc, ix, sp;
        logic [7:0] a, b, top;
        logic [5:0] ccr;
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        mem[10'h3F8] = 8'h12; mem[10'h3F9] = 8'h34;
        mem[10'h3FA] = 8'h56; mem[10'h3FB] = 8'h78;
        mem[10'h3FC] = 8'h9A; mem[10'h3FD] = 8'hBC;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 busy in reset", {31'd0, busy}, 0);
        chk("R12 done in reset", {31'd0, done}, 0);
        chk("R12 we in reset", {31'd0, mem_we}, 0);
        rst = 0;
        @(negedge clk);
        chk("R12 busy after reset", {31'd0, busy}, 0);

        // Directed software entry followed by return
        set_ctx(16'hC123, 16'h4567, 8'hA5, 8'h5A, 6'h2B, 16'h01F0);
        swi_req = 1;
        wait_done(e);
        chk("R9 entry cycles", e, 10);
        chk_entry(16'hC123, 16'h4567, 8'hA5, 8'h5A, 6'h2B, 16'h01F0, 16'hFFFA);
        mem[10'h1EA] = 8'h2B; // bits 7:6 cleared in stacked byte
        set_ctx(16'h0, 16'h0, 8'h0, 8'h0, 6'h3F, 16'h01E9);
        rti_req = 1;
        wait_done(e);
        chk("R9 return cycles", e, 8);
        chk("R8 ccr", ccr_out, 6'h2B);
        chk("R8 pc", pc_out, 16'hC123);
        chk("R8 ix", ix_out, 16'h4567);
        chk("R8 a", a_out, 8'hA5);
        chk("R8 b", b_out, 8'h5A);
        chk("R8 sp", sp_out, 16'h01F0);

        // Masked IRQ and IRQ off the boundary are not taken
        set_ctx(16'h2000, 16'h1, 8'h1, 8'h2, 6'h10, 16'h0200);
        irq_n = 0; insn_end = 1;
        repeat (3) @(negedge clk);
        chk("R6 masked irq", {31'd0, busy}, 0);
        ccr_in = 6'h00; insn_end = 0;
        repeat (3) @(negedge clk);
        chk("R6 irq off boundary", {31'd0, busy}, 0);
        insn_end = 1;
        wait_done(e);
        chk("R6 irq taken cycles", e, 10);
        chk_entry(16'h2000, 16'h1, 8'h1, 8'h2, 6'h00, 16'h0200, 16'hFFF8);
        irq_n = 1;

        // NMI edge, held low does not retrigger
        set_ctx(16'h3000, 16'h2, 8'h3, 8'h4, 6'h15, 16'h0280);
        nmi_n = 0;
        @(negedge clk);
        insn_end = 1;
        wait_done(e);
        chk_entry(16'h3000, 16'h2, 8'h3, 8'h4, 6'h15, 16'h0280, 16'hFFFC);
        insn_end = 1;
        repeat (4) @(negedge clk);
        chk("R5 nmi held low no retake", {31'd0, busy}, 0);
        insn_end = 0; nmi_n = 1;
        @(negedge clk);

        // Priority: NMI over IRQ and SWI
        set_ctx(16'h4000, 16'h3, 8'h5, 8'h6, 6'h00, 16'h0300);
        nmi_n = 0;
        @(negedge clk);
        irq_n = 0; swi_req = 1; insn_end = 1;
        wait_done(e);
        chk("R7 nmi wins pc", pc_out, 16'h9ABC);
        nmi_n = 1;
        // IRQ over SWI
        set_ctx(16'h4100, 16'h3, 8'h5, 8'h6, 6'h00, 16'h0300);
        swi_req = 1; insn_end = 1;
        wait_done(e);
        chk("R7 irq wins pc", pc_out, 16'h1234);
        irq_n = 1;
        // SWI over RTI
        swi_req = 1; rti_req = 1;
        wait_done(e);
        chk("R7 swi beats rti cycles", e, 10);
        chk("R7 swi beats rti pc", pc_out, 16'h5678);

        // Requests while busy are dropped; NMI edge while busy stays pending
        set_ctx(16'h5000, 16'h4, 8'h7, 8'h8, 6'h00, 16'h0180);
        swi_req = 1;
        @(posedge clk);
        @(negedge clk);
        swi_req = 0;
        repeat (2) @(negedge clk);
        swi_req = 1; rti_req = 1; nmi_n = 0;
        @(negedge clk);
        swi_req = 0; rti_req = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 busy-time requests dropped", {31'd0, busy}, 0);
        set_ctx(16'h6000, 16'h5, 8'h9, 8'hA, 6'h01, 16'h0190);
        insn_end = 1;
        wait_done(e);
        chk("R10 nmi edge during busy kept", pc_out, 16'h9ABC);
        nmi_n = 1;
        @(negedge clk);

        // Random round trips
        for (int it = 0; it < 24; it++) begin
            pc = 16'($urandom); ix = 16'($urandom); a = 8'($urandom); b = 8'($urandom);
            ccr = 6'($urandom); sp = 16'h0100 + 16'($urandom % 16'h0200);
            top = 8'($urandom);
            set_ctx(pc, ix, a, b, ccr, sp);
            swi_req = 1;
            wait_done(e);
            chk("R9 rand entry cycles", e, 10);
            chk_entry(pc, ix, a, b, ccr, sp, 16'hFFFA);
            mem[(sp - 16'd6) & 16'h3FF] = {top[7:6], ccr};
            set_ctx(16'h0, 16'h0, 8'h0, 8'h0, 6'($urandom), sp_out);
            rti_req = 1;
            wait_done(e);
            chk("R8 rand ccr", ccr_out, ccr);
            chk("R8 rand pc", pc_out, pc);
            chk("R8 rand ix", ix_out, ix);
            chk("R8 rand a", a_out, a);
            chk("R8 rand b", b_out, b);
            chk("R8 rand sp", sp_out, sp);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule